// File: doc/BRIEF.md
# Strobed Programmable Watchdog Timer

This block is a watchdog that counts down on a slow enable pulse (nominally 32 Hz, so one count is 31.25 ms). Software sets a 6-bit period multiplier and must restart the countdown by writing a strobe bit before the count runs out. When the count does run out, a sticky watchdog flag is raised. The flag is also offered to an interrupt controller as a request when the watchdog interrupt is enabled.

The period field has a lock bit next to it. With the lock set, software can strobe without any risk of changing the period. A period of zero stops the watchdog completely. The slow pulse comes from outside the block, and so does any pin driver for the request.

Top module: `wdog_strobe_timer`

## Requirements
- R1: After reset the period is 0, the lock is 0, the internal count is 0, the flag is 0, the interrupt enable is 0 and `irq_req` is low.
- R2: The control register sits at address 0. Bit 7 is the strobe, bit 6 is the lock, and bits 5:0 are the period. A read of this register returns {0, lock, period}.
- R3: Writing address 0 with bit 7 set reloads the count from the period and restarts the countdown, whether or not the lock is set. The strobe bit always reads back as 0.
- R4: The count drops by one on each cycle where `tick_en` is high. For a period N (1 to 63), `wd_flag` rises on the clock edge that ends the Nth tick after a reload.
- R5: A period of 0 disables the watchdog. No number of ticks sets the flag, and neither does a strobe.
- R6: Every control write stores bit 6 as the new lock. Bits 5:0 are accepted only if the lock was already 0 before that write. Otherwise the period is left unchanged.
- R7: An accepted nonzero period write reloads the count, including when it moves the watchdog out of the disabled state.
- R8: Each countdown produces one expiry only. Once the flag has been cleared, further ticks do not raise it again until the next reload.
- R9: The flag stays set until software reads the flags register at address 2, where the flag is bit 0. That read returns the flag and clears it. If an expiry and the clearing read fall in the same cycle, the flag stays set.
- R10: The interrupt enable is bit 0 at address 1. `irq_req` equals the flag ANDed with that enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle enable pulse at the slow count rate |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading the flags register clears the flag) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| wd_flag | output | 1 | Sticky watchdog expiry flag |
| irq_req | output | 1 | Interrupt request toward the controller |

## Verification
The bench places ticks one at a time around each expiry. A count that is off by one therefore shows up as a flag that is already set after N-1 ticks, or still clear after N. It tries to change the period while the lock is set, and it sends an unlocking write that carries a new period. A design that looks at the lock after the write has updated it would accept that new period. It runs more than 63 ticks with a period of 0, including after a strobe, so a design that counts while disabled would raise the flag. After an expiry has been cleared, it sends further ticks to catch a counter that wraps around and fires a second time.

// File: rtl/wdog_strobe_timer.sv
module wdog_strobe_timer #(
  parameter int TMO_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [TMO_W+1:0] bus_wdata,
  output logic [TMO_W+1:0] bus_rdata,
  output logic             wd_flag,
  output logic             irq_req
);
  localparam int DW = TMO_W + 2;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_IEN  = 2'd1;
  localparam logic [1:0] A_FLAG = 2'd2;
  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic [TMO_W-1:0] tmo_q, cnt_q;
  logic             lock_q, ien_q, flag_q;

  wire wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  wire wr_ien  = bus_wr && (bus_addr == A_IEN);
  wire rd_flag = bus_rd && (bus_addr == A_FLAG);
  wire tmo_acc = wr_ctrl && !lock_q;
  wire [TMO_W-1:0] tmo_nx = tmo_acc ? bus_wdata[TMO_W-1:0] : tmo_q;
  wire strobe  = wr_ctrl && bus_wdata[DW-1];
  wire reload  = strobe || (tmo_acc && (bus_wdata[TMO_W-1:0] != '0));
  wire expire  = tick_en && !reload && (tmo_q != '0) && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= '0;
      lock_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      tmo_q <= tmo_nx;
      if (wr_ctrl) lock_q <= bus_wdata[DW-2];
      if (wr_ien)  ien_q  <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (tmo_nx == '0)           cnt_q <= '0;
    else if (reload)                 cnt_q <= tmo_nx;
    else if (tick_en && cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (expire)  flag_q <= 1'b1;
    else if (rd_flag) flag_q <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {1'b0, lock_q, tmo_q};
      A_IEN:   bus_rdata = {{(DW-1){1'b0}}, ien_q};
      A_FLAG:  bus_rdata = {{(DW-1){1'b0}}, flag_q};
      default: bus_rdata = '0;
    endcase
  end

  assign wd_flag = flag_q;
  assign irq_req = flag_q & ien_q;

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= tmo_q);
  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && lock_q) |=> $stable(tmo_q));
  // R8
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick_en && cnt_q == ONE));
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !rd_flag) |=> flag_q);
  // R4
  expiry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt_q == ONE && tmo_q != '0 && !bus_wr) |=> flag_q);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (flag_q && ien_q));
endmodule

// File: tb/test_wdog_strobe_timer.sv
module test_wdog_strobe_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic wd_flag, irq_req;
  int n_cmp = 0, n_bad = 0;

  typedef struct { logic [7:0] data; logic irq; string req; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  wdog_strobe_timer i_wdog_strobe_timer (.*);

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] d, input logic irq, input string req);
    exp_t e;
    e.data = d; e.irq = irq; e.req = req;
    sb.push_back(e);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tick_en = 1'b1;
      @(posedge clk); #1; tick_en = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL %s: read with empty scoreboard, got %h", "any", bus_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        n_cmp++;
        if (bus_rdata !== e.data || irq_req !== e.irq) begin
          n_bad++;
          $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                   e.req, bus_rdata, irq_req, e.data, e.irq);
        end
      end
    end
  end

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog: bench timed out");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, 8'h00, 1'b0, "R1");
    rd(2'd1, 8'h00, 1'b0, "R1");
    rd(2'd2, 8'h00, 1'b0, "R1");
    wr(2'd1, 8'h01);
    rd(2'd1, 8'h01, 1'b0, "R10");
    // R7 load period 5, R2 layout
    wr(2'd0, 8'h05);
    rd(2'd0, 8'h05, 1'b0, "R2");
    ticks(4);
    rd(2'd2, 8'h00, 1'b0, "R4");
    ticks(1);
    rd(2'd2, 8'h01, 1'b1, "R4");
    rd(2'd2, 8'h00, 1'b0, "R9");
    ticks(10);
    rd(2'd2, 8'h00, 1'b0, "R8");
    // R3 strobe restarts and reads 0
    wr(2'd0, 8'h85);
    rd(2'd0, 8'h05, 1'b0, "R3");
    ticks(2);
    wr(2'd0, 8'h85);
    ticks(4);
    rd(2'd2, 8'h00, 1'b0, "R3");
    ticks(1);
    rd(2'd2, 8'h01, 1'b1, "R3");
    // R6 lock behaviour
    wr(2'd0, 8'h45);
    rd(2'd0, 8'h45, 1'b0, "R6");
    wr(2'd0, 8'h4A);
    rd(2'd0, 8'h45, 1'b0, "R6");
    wr(2'd0, 8'hC0);
    rd(2'd0, 8'h45, 1'b0, "R6");
    ticks(4);
    rd(2'd2, 8'h00, 1'b0, "R3");
    ticks(1);
    rd(2'd2, 8'h01, 1'b1, "R3");
    wr(2'd0, 8'h03);
    rd(2'd0, 8'h05, 1'b0, "R6");
    wr(2'd0, 8'h03);
    rd(2'd0, 8'h03, 1'b0, "R6");
    // R5 disabled
    wr(2'd0, 8'h00);
    rd(2'd0, 8'h00, 1'b0, "R5");
    ticks(70);
    rd(2'd2, 8'h00, 1'b0, "R5");
    wr(2'd0, 8'h80);
    ticks(70);
    rd(2'd2, 8'h00, 1'b0, "R5");
    // R7 leaving disabled reloads
    wr(2'd0, 8'h02);
    ticks(1);
    rd(2'd2, 8'h00, 1'b0, "R7");
    ticks(1);
    rd(2'd2, 8'h01, 1'b1, "R7");
    // R10 gating, R9 sticky over further ticks
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h82);
    ticks(7);
    rd(2'd2, 8'h01, 1'b0, "R10");
    rd(2'd2, 8'h00, 1'b0, "R9");
    // R4 maximum period
    wr(2'd0, 8'h3F);
    ticks(62);
    rd(2'd2, 8'h00, 1'b0, "R4");
    ticks(1);
    rd(2'd2, 8'h01, 1'b0, "R4");
    repeat (3) @(posedge clk);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL any: %0d reads left unchecked, expected 0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule